// File: doc/BRIEF.md
# Flash Programming Sequencer with Write Polling

This block is the target-side controller for in-system programming of an on-chip code flash. The flash is modelled as a byte array. A host sends one command per cycle. A command can read a byte, write a byte, erase the whole array, program the protection bits, or set or clear the serial-disable fuse. Each command carries a mode flag that selects the parallel or the serial programming path. The two paths differ in three ways: whether a byte write erases the target first, how long a chip erase lasts, and which commands they may issue.

Byte writes, protection-bit programming and chip erase are self-timed. Their lengths are set by cycle-count parameters, so simulations can use short values. While a cycle runs, `ready` is low. The host can poll the byte being written: until the write finishes, the top bit of that byte reads back inverted. Reads issued during a chip erase return zero. When both protection bits are programmed, code readback is blocked. Once the fuse is programmed, the serial path is shut off. Reset clears the sequencing state only. The array contents, the protection bits and the fuse are kept.

Top module: `flash_prog_seq`

## Requirements
- R1: Every in-range address (0 to DEPTH-1) of an erased array reads 8'hFF. The array comes up erased.
- R2: A byte write (op 3'd1) issued with `cmd_serial`=1 replaces the stored byte with the written value, because the serial path erases the byte first.
- R3: A byte write issued with `cmd_serial`=0 stores the bitwise AND of the old and the new byte. A bit that is already 0 stays 0 until a chip erase.
- R4: After a write or protection-bit command is accepted, `ready` is low for exactly WRITE_CYC cycles. After a chip erase (op 3'd2) is accepted, `ready` is low for SER_ERASE_CYC cycles on the serial path and PAR_ERASE_CYC cycles on the parallel path.
- R5: While a byte write is in progress, a read of its address returns the written byte with bit 7 inverted. This holds up to and including the cycle in which the write completes. Afterwards the true byte is returned.
- R6: Every read accepted while a chip erase is running returns 8'h00, including reads of out-of-range addresses. When the erase completes, every location reads 8'hFF and both protection bits are cleared.
- R7: A command other than a read that arrives while `ready` is low is ignored and sets `err`. `err` stays set until reset.
- R8: A write to an address at or above DEPTH leaves the array unchanged and sets `err`. A read of such an address returns 8'hFF.
- R9: The protection command (op 3'd3) ORs `cmd_wdata[1:0]` into the protection bits (bit 0 and bit 1) when its timed cycle ends. With both bits set, code reads return 8'hFF. With either bit set, a serial byte write is refused and sets `err`.
- R10: Op 3'd4 on the parallel path programs the fuse, and op 3'd5 on the parallel path clears it. While the fuse is programmed, every serial command is ignored, gets no read response and sets `err`. Ops 3'd4 and 3'd5 issued on the serial path are refused and set `err`.
- R11: Reset makes `ready`=1, `err`=0 and `rd_valid`=0. It leaves the array, the protection bits and the fuse unchanged.
- R12: An accepted read (op 3'd0) is answered in the next cycle with `rd_valid` high for one cycle. Reads are accepted even while busy. Ops 3'd6 and 3'd7 are refused and set `err`. Read result priority, from highest to lowest: erase running, out of range, write polling, readback blocked, array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_serial | input | 1 | 1 = serial path, 0 = parallel path |
| cmd_op | input | 3 | Operation code (0 read, 1 write, 2 erase, 3 protect, 4 fuse program, 5 fuse clear) |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 8 | Write data, or protection bits in [1:0] |
| ready | output | 1 | High when no timed cycle is running |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| err | output | 1 | Sticky refusal flag |

## Verification
Two things can happen in the same cycle: a byte write reaching its final count, and a polling read of that byte being accepted. The bench counts the cycles from the accepting edge so that the read lands exactly on the completing edge. That read must still return the inverted top bit, and the read one cycle later must return the true byte. The completion edge also serves as the check on `ready`, which must be low in the cycle before and high right after. The bench repeats this with a second write that goes through the parallel path.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_ERASE    = 3'd2,
        OP_PROTECT  = 3'd3,
        OP_FUSE_SET = 3'd4,
        OP_FUSE_CLR = 3'd5
    } fsp_op_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_BYTE    = 2'd1,
        PH_PROTECT = 2'd2,
        PH_ERASE   = 2'd3
    } fsp_phase_e;

endpackage

// File: rtl/fsp_timer.sv
module fsp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = len - CNT_W'(1);
        end else if (t_q.run) begin
            if (t_q.cnt == '0) begin
                t_d.run = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign expire = t_q.run && (t_q.cnt == '0);

    AST_TMR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start) |=> !expire); // R4

endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
    parameter int DEPTH = 3072,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             merge,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             erase_all,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem_q [DEPTH] = '{default: 8'hFF};

    always_ff @(posedge clk) begin
        if (erase_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (we) begin
            mem_q[waddr] <= merge ? (mem_q[waddr] & wdata) : wdata;
        end
    end

    assign rdata = mem_q[raddr];

    AST_ARR_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !erase_all); // R6

endmodule

// File: rtl/fsp_rdsel.sv
module fsp_rdsel (
    input  logic       erasing,
    input  logic       in_range,
    input  logic       poll_hit,
    input  logic       blocked,
    input  logic [7:0] poll_byte,
    input  logic [7:0] arr_byte,
    output logic [7:0] rd_byte
);

    always_comb begin
        if (erasing) begin
            rd_byte = 8'h00;
        end else if (!in_range) begin
            rd_byte = 8'hFF;
        end else if (poll_hit) begin
            rd_byte = {~poll_byte[7], poll_byte[6:0]};
        end else if (blocked) begin
            rd_byte = 8'hFF;
        end else begin
            rd_byte = arr_byte;
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fsp_pkg::*;
#(
    parameter int DEPTH         = 3072,
    parameter int ADDR_W        = 14,
    parameter int WRITE_CYC     = 24,
    parameter int SER_ERASE_CYC = 64,
    parameter int PAR_ERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_serial,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              err
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int MAX_A = (WRITE_CYC > SER_ERASE_CYC) ? WRITE_CYC : SER_ERASE_CYC;
    localparam int MAX_C = (MAX_A > PAR_ERASE_CYC) ? MAX_A : PAR_ERASE_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

    typedef struct packed {
        fsp_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              serial;
        logic [1:0]        prot;
        logic              fuse;
        logic              err;
        logic              rvalid;
        logic [7:0]        rdata;
    } seq_t;

    seq_t s_q = '0;
    seq_t s_d;

    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expire;
    logic             arr_we;
    logic             arr_erase;
    logic [7:0]       arr_byte;
    logic [7:0]       rd_byte;
    logic             busy;
    logic             in_range;
    logic             poll_hit;

    assign busy     = (s_q.phase != PH_IDLE);
    assign in_range = (cmd_addr < LIMIT);
    assign poll_hit = (s_q.phase == PH_BYTE) && (cmd_addr == s_q.addr);

    fsp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    fsp_array #(.DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (arr_we),
        .merge     (!s_q.serial),
        .waddr     (s_q.addr[IDX_W-1:0]),
        .wdata     (s_q.data),
        .erase_all (arr_erase),
        .raddr     (cmd_addr[IDX_W-1:0]),
        .rdata     (arr_byte)
    );

    fsp_rdsel u_rdsel (
        .erasing   (s_q.phase == PH_ERASE),
        .in_range  (in_range),
        .poll_hit  (poll_hit),
        .blocked   (s_q.prot == 2'b11),
        .poll_byte (s_q.data),
        .arr_byte  (arr_byte),
        .rd_byte   (rd_byte)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rvalid = 1'b0;
        tmr_start = 1'b0;
        tmr_len   = '0;
        arr_we    = 1'b0;
        arr_erase = 1'b0;

        if (tmr_expire) begin
            case (s_q.phase)
                PH_BYTE:    arr_we = 1'b1;
                PH_PROTECT: s_d.prot = s_q.prot | s_q.data[1:0];
                PH_ERASE: begin
                    arr_erase = 1'b1;
                    s_d.prot  = 2'b00;
                end
                default: ;
            endcase
            s_d.phase = PH_IDLE;
        end

        if (cmd_valid) begin
            if (cmd_serial && s_q.fuse) begin
                s_d.err = 1'b1;
            end else if (cmd_op == OP_READ) begin
                s_d.rvalid = 1'b1;
                s_d.rdata  = rd_byte;
            end else if (busy) begin
                s_d.err = 1'b1;
            end else begin
                case (cmd_op)
                    OP_WRITE: begin
                        if (!in_range || (cmd_serial && (s_q.prot != 2'b00))) begin
                            s_d.err = 1'b1;
                        end else begin
                            s_d.phase  = PH_BYTE;
                            s_d.addr   = cmd_addr;
                            s_d.data   = cmd_wdata;
                            s_d.serial = cmd_serial;
                            tmr_start  = 1'b1;
                            tmr_len    = CNT_W'(WRITE_CYC);
                        end
                    end
                    OP_ERASE: begin
                        s_d.phase = PH_ERASE;
                        tmr_start = 1'b1;
                        tmr_len   = cmd_serial ? CNT_W'(SER_ERASE_CYC)
                                               : CNT_W'(PAR_ERASE_CYC);
                    end
                    OP_PROTECT: begin
                        s_d.phase = PH_PROTECT;
                        s_d.data  = cmd_wdata;
                        tmr_start = 1'b1;
                        tmr_len   = CNT_W'(WRITE_CYC);
                    end
                    OP_FUSE_SET: begin
                        if (cmd_serial) s_d.err = 1'b1;
                        else            s_d.fuse = 1'b1;
                    end
                    OP_FUSE_CLR: begin
                        if (cmd_serial) s_d.err = 1'b1;
                        else            s_d.fuse = 1'b0;
                    end
                    default: s_d.err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.err    <= 1'b0;
            s_q.rvalid <= 1'b0;
            s_q.rdata  <= 8'h00;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready    = !busy;
    assign rd_valid = s_q.rvalid;
    assign rd_data  = s_q.rdata;
    assign err      = s_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err); // R7

    AST_ERASE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rvalid && $past(s_q.phase == PH_ERASE)) |-> (s_q.rdata == 8'h00)); // R6

    AST_PROT_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.prot) |-> $past(tmr_expire)); // R9

    AST_FUSE_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.fuse) |-> $past(cmd_valid && !cmd_serial)); // R10

    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rvalid |-> $past(cmd_valid && (cmd_op == OP_READ))); // R12

    AST_BUSY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |-> busy); // R4

endmodule

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;
    import fsp_pkg::*;

    localparam int DEPTH  = 3072;
    localparam int ADDR_W = 14;
    localparam int WCYC   = 24;
    localparam int SECYC  = 64;
    localparam int PECYC  = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_serial = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_wdata = 8'h00;
    logic              ready;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              err;

    int checks = 0;
    int errors = 0;
    int rsp_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] exp_v[$];
    string      exp_tag[$];

    always #5 clk = ~clk;

    flash_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_serial(cmd_serial),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected byte per read response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            rsp_cnt++;
            if (exp_v.size() == 0) begin
                check(1'b0, "R12", "unexpected read response", int'(rd_data), 0);
            end else begin
                automatic logic [7:0] e = exp_v.pop_front();
                automatic string t = exp_tag.pop_front();
                check(rd_data == e, t, "read data", int'(rd_data), int'(e));
            end
        end
    end

    // driver: called at a negedge, returns at the next negedge
    task automatic issue(input bit ser, input logic [2:0] op,
                         input int addr, input logic [7:0] d);
        cmd_valid  = 1'b1;
        cmd_serial = ser;
        cmd_op     = op;
        cmd_addr   = ADDR_W'(addr);
        cmd_wdata  = d;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic rd_expect(input bit ser, input int addr, input logic [7:0] e,
                             input string tag);
        exp_v.push_back(e);
        exp_tag.push_back(tag);
        issue(ser, OP_READ, addr, 8'h00);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int r0;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state
        check(ready == 1'b1, "R11", "ready after reset", int'(ready), 1);
        check(err == 1'b0, "R11", "err after reset", int'(err), 0);
        check(rd_valid == 1'b0, "R11", "rd_valid after reset", int'(rd_valid), 0);

        // R1 erased reads at both ends
        rd_expect(1'b0, 0, 8'hFF, "R1");
        rd_expect(1'b1, DEPTH - 1, 8'hFF, "R1");
        idle(2);

        // R2 / R4 serial write auto-erase and write length
        issue(1'b1, OP_WRITE, 10, 8'h5A);
        busy_len(n);
        check(n == WCYC, "R4", "write busy cycles", n, WCYC);
        rd_expect(1'b0, 10, 8'h5A, "R2");
        issue(1'b1, OP_WRITE, 10, 8'hA5);
        wait_ready();
        rd_expect(1'b1, 10, 8'hA5, "R2");

        // R3 parallel write ANDs
        issue(1'b0, OP_WRITE, 20, 8'hF0);
        wait_ready();
        issue(1'b0, OP_WRITE, 20, 8'h3C);
        wait_ready();
        rd_expect(1'b0, 20, 8'h30, "R3");

        // R5 polling, including the completion edge
        issue(1'b1, OP_WRITE, 30, 8'h47);
        rd_expect(1'b1, 30, 8'hC7, "R5");
        idle(WCYC - 2);
        check(ready == 1'b0, "R4", "ready before completion", int'(ready), 0);
        rd_expect(1'b1, 30, 8'hC7, "R5");
        check(ready == 1'b1, "R4", "ready after completion", int'(ready), 1);
        rd_expect(1'b1, 30, 8'h47, "R5");

        issue(1'b0, OP_WRITE, 31, 8'hB2);
        rd_expect(1'b0, 31, 8'h32, "R5");
        idle(WCYC - 2);
        rd_expect(1'b0, 31, 8'h32, "R5");
        rd_expect(1'b0, 31, 8'hB2, "R5");

        // R7 commands while busy
        issue(1'b1, OP_WRITE, 40, 8'h11);
        issue(1'b1, OP_WRITE, 41, 8'h22);
        check(err == 1'b1, "R7", "err on busy write", int'(err), 1);
        issue(1'b0, OP_ERASE, 0, 8'h00);
        wait_ready();
        idle(3);
        check(err == 1'b1, "R7", "err sticky", int'(err), 1);
        rd_expect(1'b1, 41, 8'hFF, "R7");
        rd_expect(1'b1, 40, 8'h11, "R7");
        idle(1);
        do_reset();
        check(err == 1'b0, "R11", "err cleared by reset", int'(err), 0);
        rd_expect(1'b1, 40, 8'h11, "R11");

        // R8 out of range
        issue(1'b0, OP_WRITE, DEPTH, 8'h00);
        check(err == 1'b1, "R8", "err on out-of-range write", int'(err), 1);
        check(ready == 1'b1, "R8", "no cycle started", int'(ready), 1);
        rd_expect(1'b0, DEPTH, 8'hFF, "R8");
        rd_expect(1'b1, (1 << ADDR_W) - 1, 8'hFF, "R8");
        idle(1);
        do_reset();

        // R9 protection bits
        issue(1'b0, OP_PROTECT, 0, 8'h01);
        busy_len(n);
        check(n == WCYC, "R4", "protect busy cycles", n, WCYC);
        rd_expect(1'b0, 10, 8'hA5, "R9");
        issue(1'b1, OP_WRITE, 12, 8'h00);
        check(err == 1'b1, "R9", "serial write refused", int'(err), 1);
        check(ready == 1'b1, "R9", "refused write idle", int'(ready), 1);
        rd_expect(1'b0, 12, 8'hFF, "R9");
        idle(1);
        do_reset();
        issue(1'b1, OP_WRITE, 12, 8'h00);
        check(err == 1'b1, "R11", "protection kept over reset", int'(err), 1);
        do_reset();
        issue(1'b0, OP_PROTECT, 0, 8'h02);
        wait_ready();
        rd_expect(1'b0, 10, 8'hFF, "R9");
        rd_expect(1'b1, 40, 8'hFF, "R9");

        // R6 / R4 erase
        issue(1'b1, OP_ERASE, 0, 8'h00);
        busy_len(n);
        check(n == SECYC, "R4", "serial erase busy cycles", n, SECYC);
        rd_expect(1'b0, 10, 8'hFF, "R6");
        rd_expect(1'b1, 40, 8'hFF, "R6");
        issue(1'b1, OP_WRITE, 50, 8'h66);
        wait_ready();
        check(err == 1'b0, "R6", "protection cleared by erase", int'(err), 0);
        issue(1'b0, OP_ERASE, 0, 8'h00);
        rd_expect(1'b0, 50, 8'h00, "R6");
        rd_expect(1'b1, DEPTH + 5, 8'h00, "R6");
        wait_ready();
        rd_expect(1'b1, 50, 8'hFF, "R6");
        issue(1'b0, OP_ERASE, 0, 8'h00);
        busy_len(n);
        check(n == PECYC, "R4", "parallel erase busy cycles", n, PECYC);

        // R10 fuse
        issue(1'b0, OP_FUSE_SET, 0, 8'h00);
        idle(1);
        r0 = rsp_cnt;
        issue(1'b1, OP_READ, 10, 8'h00);
        idle(2);
        check(rsp_cnt == r0, "R10", "serial read ignored", rsp_cnt - r0, 0);
        check(err == 1'b1, "R10", "err on serial when fused", int'(err), 1);
        issue(1'b1, OP_FUSE_CLR, 0, 8'h00);
        do_reset();
        r0 = rsp_cnt;
        issue(1'b1, OP_READ, 10, 8'h00);
        idle(2);
        check(rsp_cnt == r0, "R11", "fuse kept over reset", rsp_cnt - r0, 0);
        do_reset();
        issue(1'b0, OP_FUSE_CLR, 0, 8'h00);
        rd_expect(1'b1, 10, 8'hFF, "R10");
        idle(1);
        check(err == 1'b0, "R10", "serial restored", int'(err), 0);
        issue(1'b0, OP_FUSE_SET, 0, 8'h00);
        issue(1'b0, OP_FUSE_CLR, 0, 8'h00);
        issue(1'b1, OP_FUSE_SET, 0, 8'h00);
        check(err == 1'b1, "R10", "serial fuse change refused", int'(err), 1);
        do_reset();
        rd_expect(1'b1, 11, 8'hFF, "R10");
        idle(1);

        // R12 reserved op codes
        issue(1'b0, 3'd6, 0, 8'h00);
        check(err == 1'b1, "R12", "reserved op refused", int'(err), 1);
        check(ready == 1'b1, "R12", "reserved op starts nothing", int'(ready), 1);
        idle(2);
        check(exp_v.size() == 0, "R12", "responses outstanding", exp_v.size(), 0);

        summary();
        finished = 1'b1;
        $finish;
    end

endmodule